// File: doc/BRIEF.md
# Flag-Generating ALU with Packed Status Word

This block is a 16-bit arithmetic and logic unit joined to a flags register. It adds, adds with the stored carry, subtracts, subtracts with the stored borrow, compares, and performs bitwise AND, OR and XOR. Each operation runs on either the full 16-bit word or the low byte. Six status flags are derived from every committed operation: carry/borrow, parity, nibble carry, zero, sign and signed overflow. Three control flags (direction, interrupt enable, trap) live in the same word. Only explicit set and clear commands change the control flags; the arithmetic never touches them.

The caller presents two operands, an operation code and a width select, and raises `commit` for one cycle. On that clock edge the status flags are loaded and, for every operation except compare, the result register is loaded. Both registers are visible one cycle after the commit edge. The control-flag command inputs are independent of `commit` and act on every edge.

Top module: `alu_flags_unit`

## Requirements
- R1: While `rst` is high on a clock edge, the result register and every bit of `flags` are cleared to zero.
- R2: `flags` packs carry at bit 0, parity at bit 2, nibble carry at bit 4, zero at bit 6, sign at bit 7, trap at bit 8, interrupt enable at bit 9, direction at bit 10 and overflow at bit 11; bits 1, 3, 5 and 12 to 15 always read zero.
- R3: `op_code` selects 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR, 7 compare. Codes 1 and 3 fold in the stored carry flag. The carry flag is the carry out of the top bit on add and the borrow on subtract.
- R4: The zero flag is set when the selected-width result is zero. The sign flag copies the top bit of the selected width.
- R5: The parity flag is set when the low 8 bits of the result hold an even number of ones.
- R6: The nibble carry flag is the carry (add) or borrow (subtract) out of bit 3.
- R7: The overflow flag is set when the signed result does not fit the selected width.
- R8: With `byte_mode` high, only operand bits 7:0 are used, result bits 15:8 are zero, and carry, sign and overflow are taken at bit 7.
- R9: AND, OR and XOR clear the carry, overflow and nibble carry flags.
- R10: Compare sets the status flags exactly as subtract would, and leaves the result register unchanged.
- R11: On an edge with `commit` low, the result register and all six status flags keep their values.
- R12: `ctl_set` and `ctl_clr` bit 0 acts on trap, bit 1 on interrupt enable and bit 2 on direction. A set bit forces the flag to 1 on the edge, and a clear bit forces it to 0. Clear wins when both are raised. Without a command the flag holds, whatever `commit` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| op_code | input | 3 | Operation select |
| byte_mode | input | 1 | 1 = operate on low byte, 0 = full word |
| commit | input | 1 | Load flags (and result) on this edge |
| ctl_set | input | 3 | Control-flag set commands (trap, int, dir) |
| ctl_clr | input | 3 | Control-flag clear commands (trap, int, dir) |
| result | output | 16 | Registered result |
| flags | output | 16 | Packed flags word |

## Verification
A status update from a committed operation and a control-flag command can land on the same edge. Both write into the one packed word, so each field must take its own new value and leave the other's bits alone. The bench raises `commit` with set, clear and set-plus-clear commands in the same cycle, and also in a long random run. It compares the whole 16-bit flags word against an integer model that computes each status flag arithmetically and applies the control commands separately. A second overlap is carry chaining: a carry or borrow produced on one commit feeds the add-with-carry or subtract-with-borrow on the next. Back-to-back chained operations exercise this path.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_AND = 3'd4,
        OP_OR  = 3'd5,
        OP_XOR = 3'd6,
        OP_CMP = 3'd7
    } alu_op_e;

    // Bit positions inside the packed flags word
    localparam int FLW       = 16;
    localparam int FB_CARRY  = 0;
    localparam int FB_PAR    = 2;
    localparam int FB_AUX    = 4;
    localparam int FB_ZERO   = 6;
    localparam int FB_SIGN   = 7;
    localparam int FB_TRAP   = 8;
    localparam int FB_INTEN  = 9;
    localparam int FB_DIR    = 10;
    localparam int FB_OVF    = 11;

    localparam int CTL_N     = 3;
    localparam int PAR_W     = 8;

    typedef struct packed {
        logic ovf;
        logic sign;
        logic zero;
        logic aux;
        logic par;
        logic carry;
    } status_t;

    // bit 0 trap, bit 1 interrupt enable, bit 2 direction
    typedef struct packed {
        logic dir;
        logic inten;
        logic trap;
    } ctl_t;

    function automatic logic is_logic_op(alu_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction

    function automatic logic is_sub_op(alu_op_e op);
        return (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
    endfunction

    function automatic logic uses_carry(alu_op_e op);
        return (op == OP_ADC) || (op == OP_SBB);
    endfunction

    function automatic logic even_ones(logic [PAR_W-1:0] v);
        return ~(^v);
    endfunction

    function automatic logic [FLW-1:0] pack_flags(status_t s, ctl_t c);
        logic [FLW-1:0] w;
        w            = '0;
        w[FB_CARRY]  = s.carry;
        w[FB_PAR]    = s.par;
        w[FB_AUX]    = s.aux;
        w[FB_ZERO]   = s.zero;
        w[FB_SIGN]   = s.sign;
        w[FB_TRAP]   = c.trap;
        w[FB_INTEN]  = c.inten;
        w[FB_DIR]    = c.dir;
        w[FB_OVF]    = s.ovf;
        return w;
    endfunction

endpackage

// File: rtl/alu_core.sv
module alu_core
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  alu_op_e           op,
    input  logic              byte_mode,
    input  logic              carry_in,
    output logic [DATA_W-1:0] res,
    output logic              carry_raw,
    output logic              aux_raw,
    output logic              ovf_raw,
    output logic              msb
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] a_m, b_m;
    logic [DATA_W:0]   ext;
    logic              cin;
    logic              a_top, b_top;

    always_comb begin
        a_m = byte_mode ? {{(DATA_W-HALF_W){1'b0}}, a[HALF_W-1:0]} : a;
        b_m = byte_mode ? {{(DATA_W-HALF_W){1'b0}}, b[HALF_W-1:0]} : b;
    end

    assign cin = uses_carry(op) & carry_in;

    always_comb begin
        case (op)
            OP_ADD, OP_ADC:
                ext = {1'b0, a_m} + {1'b0, b_m} + {{DATA_W{1'b0}}, cin};
            OP_SUB, OP_SBB, OP_CMP:
                ext = {1'b0, a_m} - {1'b0, b_m} - {{DATA_W{1'b0}}, cin};
            OP_AND:  ext = {1'b0, a_m & b_m};
            OP_OR:   ext = {1'b0, a_m | b_m};
            OP_XOR:  ext = {1'b0, a_m ^ b_m};
            default: ext = '0;
        endcase
    end

    always_comb begin
        if (byte_mode) begin
            res       = {{(DATA_W-HALF_W){1'b0}}, ext[HALF_W-1:0]};
            carry_raw = ext[HALF_W];
            a_top     = a_m[HALF_W-1];
            b_top     = b_m[HALF_W-1];
            msb       = ext[HALF_W-1];
        end else begin
            res       = ext[DATA_W-1:0];
            carry_raw = ext[DATA_W];
            a_top     = a_m[DATA_W-1];
            b_top     = b_m[DATA_W-1];
            msb       = ext[DATA_W-1];
        end
    end

    // carry/borrow out of bit 3 is visible as the bit-4 difference
    assign aux_raw = a_m[4] ^ b_m[4] ^ ext[4];

    always_comb begin
        if (is_sub_op(op))
            ovf_raw = (a_top != b_top) && (msb != a_top);
        else
            ovf_raw = (a_top == b_top) && (msb != a_top);
    end

endmodule

// File: rtl/alu_status_gen.sv
module alu_status_gen
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] res,
    input  logic              carry_raw,
    input  logic              aux_raw,
    input  logic              ovf_raw,
    input  logic              msb,
    output status_t           st
);
    logic logic_op;

    assign logic_op = is_logic_op(op);

    always_comb begin
        st.zero  = (res == '0);
        st.sign  = msb;
        st.par   = even_ones(res[PAR_W-1:0]);
        st.carry = logic_op ? 1'b0 : carry_raw;
        st.aux   = logic_op ? 1'b0 : aux_raw;
        st.ovf   = logic_op ? 1'b0 : ovf_raw;
    end

endmodule

// File: rtl/alu_ctl_flags.sv
module alu_ctl_flags
    import alu_flags_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CTL_N-1:0] set_cmd,
    input  logic [CTL_N-1:0] clr_cmd,
    output ctl_t             ctl
);
    logic [CTL_N-1:0] bits_q;

    for (genvar i = 0; i < CTL_N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                bits_q[i] <= 1'b0;
            else if (clr_cmd[i])
                bits_q[i] <= 1'b0;
            else if (set_cmd[i])
                bits_q[i] <= 1'b1;
        end
    end

    assign ctl = ctl_t'(bits_q);

endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [2:0]        op_code,
    input  logic              byte_mode,
    input  logic              commit,
    input  logic [CTL_N-1:0]  ctl_set,
    input  logic [CTL_N-1:0]  ctl_clr,
    output logic [DATA_W-1:0] result,
    output logic [FLW-1:0]    flags
);
    alu_op_e           op;
    logic [DATA_W-1:0] core_res;
    logic              carry_raw, aux_raw, ovf_raw, msb;
    status_t           st_nxt, st_q;
    ctl_t              ctl_q;
    logic [DATA_W-1:0] result_q;

    assign op = alu_op_e'(op_code);

    alu_core #(.DATA_W(DATA_W)) u_core (
        .a         (op_a),
        .b         (op_b),
        .op        (op),
        .byte_mode (byte_mode),
        .carry_in  (st_q.carry),
        .res       (core_res),
        .carry_raw (carry_raw),
        .aux_raw   (aux_raw),
        .ovf_raw   (ovf_raw),
        .msb       (msb)
    );

    alu_status_gen #(.DATA_W(DATA_W)) u_status (
        .op        (op),
        .res       (core_res),
        .carry_raw (carry_raw),
        .aux_raw   (aux_raw),
        .ovf_raw   (ovf_raw),
        .msb       (msb),
        .st        (st_nxt)
    );

    alu_ctl_flags u_ctl (
        .clk     (clk),
        .rst     (rst),
        .set_cmd (ctl_set),
        .clr_cmd (ctl_clr),
        .ctl     (ctl_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= '0;
            result_q <= '0;
        end else if (commit) begin
            st_q <= st_nxt;
            if (op != OP_CMP)
                result_q <= core_res;
        end
    end

    assign result = result_q;
    assign flags  = pack_flags(st_q, ctl_q);

endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              commit,
    input logic [2:0]        op_code,
    input logic [CTL_N-1:0]  ctl_set,
    input logic [CTL_N-1:0]  ctl_clr,
    input logic [DATA_W-1:0] result,
    input logic [FLW-1:0]    flags
);
    localparam logic [FLW-1:0] STATUS_MASK = 16'h08D5;
    localparam logic [FLW-1:0] UNUSED_MASK = 16'hF02A;

    logic is_cmp, is_lgc;
    assign is_cmp = (op_code == 3'd7);
    assign is_lgc = (op_code == 3'd4) || (op_code == 3'd5) || (op_code == 3'd6);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (flags == '0) && (result == '0));

    a_r2_unused_zero: assert property (@(posedge clk) disable iff (rst)
        (flags & UNUSED_MASK) == '0);

    a_r4_zero_tracks: assert property (@(posedge clk) disable iff (rst)
        (commit && !is_cmp) |=> (flags[FB_ZERO] == (result == '0)));

    a_r5_parity_tracks: assert property (@(posedge clk) disable iff (rst)
        (commit && !is_cmp) |=> (flags[FB_PAR] == ~(^result[PAR_W-1:0])));

    a_r9_logic_clears: assert property (@(posedge clk) disable iff (rst)
        (commit && is_lgc) |=> !flags[FB_CARRY] && !flags[FB_OVF] && !flags[FB_AUX]);

    a_r10_cmp_keeps_result: assert property (@(posedge clk) disable iff (rst)
        (commit && is_cmp) |=> $stable(result));

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(result) && $stable(flags & STATUS_MASK));

    a_r12_ctl_hold: assert property (@(posedge clk) disable iff (rst)
        (ctl_set == '0 && ctl_clr == '0) |=> $stable(flags[FB_DIR:FB_TRAP]));

    a_r12_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (ctl_clr != '0) |=> ((flags[FB_DIR:FB_TRAP] & $past(ctl_clr)) == '0));

    a_r12_set_takes: assert property (@(posedge clk) disable iff (rst)
        ((ctl_set & ~ctl_clr) != '0) |=>
            ((flags[FB_DIR:FB_TRAP] & $past(ctl_set & ~ctl_clr)) == $past(ctl_set & ~ctl_clr)));

endmodule

bind alu_flags_unit alu_flags_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .commit  (commit),
    .op_code (op_code),
    .ctl_set (ctl_set),
    .ctl_clr (ctl_clr),
    .result  (result),
    .flags   (flags)
);

// File: tb/alu_flags_unit_tb.sv
module alu_flags_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] op_a = '0, op_b = '0;
    logic [2:0]  op_code = '0;
    logic        byte_mode = 1'b0, commit = 1'b0;
    logic [2:0]  ctl_set = '0, ctl_clr = '0;
    logic [15:0] result, flags;

    always #2 clk = ~clk;  // 4 ns period

    alu_flags_unit u_dut (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_code(op_code),
        .byte_mode(byte_mode), .commit(commit), .ctl_set(ctl_set),
        .ctl_clr(ctl_clr), .result(result), .flags(flags)
    );

    typedef struct {
        logic [15:0] res;
        logic [15:0] fl;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    // reference state
    logic [15:0] m_res = '0;
    logic        m_cf = 0, m_pf = 0, m_af = 0, m_zf = 0, m_sf = 0, m_of = 0;
    logic [2:0]  m_ctl = '0;

    function automatic logic [15:0] m_pack();
        return {4'b0, m_of, m_ctl[2], m_ctl[1], m_ctl[0], m_sf, m_zf,
                1'b0, m_af, 1'b0, m_pf, 1'b0, m_cf};
    endfunction

    task automatic model_step(input int op, input int a, input int b, input bit bm,
                              input logic [2:0] s, input logic [2:0] c, input bit cmt);
        int n    = bm ? 8 : 16;
        int mask = (1 << n) - 1;
        int half = 1 << (n - 1);
        int au   = a & mask;
        int bu   = b & mask;
        int sa   = (au >= half) ? au - (1 << n) : au;
        int sb   = (bu >= half) ? bu - (1 << n) : bu;
        int ci   = ((op == 1) || (op == 3)) ? int'(m_cf) : 0;
        int raw  = 0;
        int sraw = 0;
        int lo   = 0;
        int ones = 0;
        logic cf = 0, af = 0, of = 0;
        logic [15:0] r;
        case (op)
            0, 1: begin
                raw = au + bu + ci; sraw = sa + sb + ci; lo = (au & 15) + (bu & 15) + ci;
                cf = (raw > mask); af = (lo > 15); of = (sraw >= half) || (sraw < -half);
            end
            2, 3, 7: begin
                raw = au - bu - ci; sraw = sa - sb - ci; lo = (au & 15) - (bu & 15) - ci;
                cf = (raw < 0); af = (lo < 0); of = (sraw >= half) || (sraw < -half);
            end
            4: raw = au & bu;
            5: raw = au | bu;
            default: raw = au ^ bu;
        endcase
        r = 16'(raw & mask);
        for (int i = 0; i < 8; i++) ones += int'(r[i]);
        if (cmt) begin
            m_cf = cf; m_af = af; m_of = of;
            m_zf = (r == 0);
            m_sf = r[n-1];
            m_pf = (ones % 2 == 0);
            if (op != 7) m_res = r;
        end
        m_ctl = (m_ctl | s) & ~c;
    endtask

    task automatic drive(input int op, input int a, input int b, input bit bm,
                         input logic [2:0] s, input logic [2:0] c, input bit cmt,
                         input string tag);
        exp_t e;
        @(negedge clk);
        op_a = 16'(a); op_b = 16'(b); op_code = 3'(op); byte_mode = bm;
        ctl_set = s; ctl_clr = c; commit = cmt;
        model_step(op, a, b, bm, s, c, cmt);
        e.res = m_res; e.fl = m_pack(); e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_chk++;
                if (result !== e.res) begin
                    n_fail++;
                    $display("FAIL %s result: actual=%h expected=%h", e.tag, result, e.res);
                end
                n_chk++;
                if (flags !== e.fl) begin
                    n_fail++;
                    $display("FAIL %s flags: actual=%h expected=%h", e.tag, flags, e.fl);
                end
                n_chk++;  // R2: unused positions stay zero
                if ((flags & 16'hF02A) !== 16'h0) begin
                    n_fail++;
                    $display("FAIL R2 unused bits: actual=%h expected=0000", flags & 16'hF02A);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_chk++;  // R1 reset state
        if (result !== 16'h0 || flags !== 16'h0) begin
            n_fail++;
            $display("FAIL R1 reset: actual=%h/%h expected=0000/0000", result, flags);
        end
        @(negedge clk);
        rst = 1'b0;

        drive(0, 16'h0001, 16'h0002, 0, 3'b000, 3'b000, 1, "R3 add");
        drive(0, 16'hFFFF, 16'h0001, 0, 3'b000, 3'b000, 1, "R4 add wrap to zero");
        drive(1, 16'h0001, 16'h0001, 0, 3'b000, 3'b000, 1, "R3 adc chained carry");
        drive(0, 16'h7FFF, 16'h0001, 0, 3'b000, 3'b000, 1, "R7 add overflow");
        drive(2, 16'h0000, 16'h0001, 0, 3'b000, 3'b000, 1, "R6 sub borrow");
        drive(3, 16'h0005, 16'h0002, 0, 3'b000, 3'b000, 1, "R3 sbb chained borrow");
        drive(2, 16'h8000, 16'h0001, 0, 3'b000, 3'b000, 1, "R7 sub overflow");
        drive(0, 16'h000F, 16'h0001, 0, 3'b000, 3'b000, 1, "R6 nibble carry");
        drive(0, 16'h12FF, 16'h3401, 1, 3'b000, 3'b000, 1, "R8 byte add carry");
        drive(2, 16'hAB80, 16'hCD01, 1, 3'b000, 3'b000, 1, "R8 byte sub overflow");
        drive(0, 16'h0040, 16'h0040, 1, 3'b000, 3'b000, 1, "R8 byte sign");
        drive(2, 16'h0000, 16'h0001, 0, 3'b000, 3'b000, 1, "R3 set carry");
        drive(4, 16'hF0F0, 16'h0FF0, 0, 3'b000, 3'b000, 1, "R9 and clears");
        drive(5, 16'h0001, 16'h0002, 0, 3'b000, 3'b000, 1, "R5 or even parity");
        drive(6, 16'h0003, 16'h0004, 0, 3'b000, 3'b000, 1, "R5 xor odd parity");
        drive(6, 16'hFF00, 16'h0000, 0, 3'b000, 3'b000, 1, "R5 parity low byte only");
        drive(0, 16'h1111, 16'h2222, 0, 3'b000, 3'b000, 1, "R3 load result");
        drive(7, 16'h1234, 16'h1234, 0, 3'b000, 3'b000, 1, "R10 cmp equal");
        drive(7, 16'h0001, 16'h0002, 0, 3'b000, 3'b000, 1, "R10 cmp below");
        drive(0, 16'hFFFF, 16'hFFFF, 0, 3'b000, 3'b000, 0, "R11 no commit");
        drive(4, 16'h0000, 16'h0000, 0, 3'b000, 3'b000, 0, "R11 no commit logic");
        drive(0, 16'h0000, 16'h0000, 0, 3'b100, 3'b000, 0, "R12 set dir");
        drive(0, 16'h4000, 16'h4000, 0, 3'b010, 3'b000, 1, "R12 set int with commit");
        drive(0, 16'h0000, 16'h0000, 0, 3'b001, 3'b001, 1, "R12 clear wins");
        drive(4, 16'hFFFF, 16'h0000, 0, 3'b000, 3'b000, 1, "R12 alu leaves ctl");
        drive(2, 16'h0003, 16'h0005, 0, 3'b001, 3'b100, 1, "R12 set trap clear dir");
        drive(0, 16'h0000, 16'h0000, 0, 3'b000, 3'b010, 0, "R12 clear int");

        for (int k = 0; k < 400; k++) begin
            drive(int'($urandom % 8), int'($urandom & 16'hFFFF), int'($urandom & 16'hFFFF),
                  bit'($urandom % 2), 3'($urandom), 3'(($urandom % 4 == 0) ? $urandom : 0),
                  bit'($urandom % 4 != 0), "R3 random");
        end

        drive(0, 0, 0, 0, 3'b000, 3'b000, 0, "R11 idle");
        repeat (3) @(posedge clk);
        #1;
        done = 1;
        summary();
        $finish;
    end

endmodule